// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps instructions in program order while their results are produced out of order. At issue it reserves the slot at its tail and returns that slot's number. The number is the tag under which the result will later arrive on the shared result broadcast. Each slot records the kind of operation, its destination index and, once broadcast, its result value and branch outcome.

A small register status table maps each architectural register to the youngest in-flight slot that will write it. Operand lookup ports use this table to report whether a register is still pending. For a pending register they give the producing slot's tag and, if that slot has already captured its result, the value itself.

At the head, one slot per cycle retires once its result is present. Retirement writes the register file, releases a store, or quietly retires a branch or no-op. If a branch reaches the head marked mispredicted, the whole buffer is discarded in that cycle and a clear pulse is driven to the surrounding rename and scheduling logic.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty (`empty_o`=1, `full_o`=0), no commit or flush is driven, and the first tag offered is 0.
- R2: A slot is granted only when `alloc_req_i` and `rs_free_i` are high, the buffer is not full and no flush is occurring. The granted tag equals the tail, and successive grants receive consecutive tags modulo the depth.
- R3: `full_o` is high exactly when all 8 slots are occupied and `empty_o` exactly when none are. A request while full is refused and leaves the contents unchanged.
- R4: A broadcast whose tag names an occupied slot without a result stores the value and mispredict flag into that slot. A broadcast naming a free slot has no effect on any later occupant of that slot.
- R5: Allocating a register-writing operation points the destination's status at the new tag. A lookup on a source register reports busy, the youngest producer's tag, ready once that slot holds its result, and the result value.
- R6: Commit happens only when the head slot holds its result, at most once per cycle, and in allocation order regardless of completion order.
- R7: The effect of a commit depends on the kind field. Kind 0 (register write) raises `commit_reg_we_o` with destination and value. Kind 1 (store) raises `commit_store_o` with the destination field as address index and the value. Kind 2 (branch) not mispredicted and kind 3 (no-op) only retire.
- R8: When a register write commits, the destination's status is cleared only if it still names the committing tag; a younger pending writer remains visible.
- R9: A kind-2 slot at the head with result present and mispredict flag set raises `flush_o` for one cycle without a commit. The next cycle every slot is empty, all register status is clear, and allocation restarts at tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Request a slot for an issuing operation |
| rs_free_i | input | 1 | A scheduling station is available for the operation |
| alloc_kind_i | input | 2 | Operation kind: 0 register write, 1 store, 2 branch, 3 no-op |
| alloc_dest_i | input | REG_W | Destination register or store address index |
| alloc_grant_o | output | 1 | Slot granted this cycle |
| alloc_tag_o | output | TAG_W | Tag of the slot offered (tail) |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |
| cdb_valid_i | input | 1 | Result broadcast valid |
| cdb_tag_i | input | TAG_W | Tag of the broadcast result |
| cdb_value_i | input | XLEN | Broadcast result value |
| cdb_mispredict_i | input | 1 | Broadcast branch was mispredicted |
| src_reg_i | input | NUM_SRC x REG_W | Source register indices to look up |
| src_busy_o | output | NUM_SRC | Source has a pending writer |
| src_ready_o | output | NUM_SRC | Pending writer has its result |
| src_tag_o | output | NUM_SRC x TAG_W | Tag of the pending writer |
| src_value_o | output | NUM_SRC x XLEN | Result held by the pending writer |
| commit_valid_o | output | 1 | Head slot retires this cycle |
| commit_reg_we_o | output | 1 | Retiring slot writes the register file |
| commit_store_o | output | 1 | Retiring slot releases a store |
| commit_idx_o | output | REG_W | Destination of the retiring slot |
| commit_value_o | output | XLEN | Result of the retiring slot |
| commit_tag_o | output | TAG_W | Tag of the retiring slot |
| flush_o | output | 1 | Mispredicted branch at head; clear all speculative state |

## Verification
The assertions check on every cycle that occupancy stays within bounds and that no push happens while full or pop while empty. They also check that the head advances by one per retirement, that captured broadcasts land in their slot, and that a commit of a stale writer never drops a younger mapping. In addition they check that a flush leaves the buffer empty with no commit or second flush behind it. Only the bench scenarios can show program-order retirement under scrambled completion orders and pointer wraparound across the end of the buffer. The same holds for ignoring a broadcast to a free slot and for the visible effect of each operation kind at the commit ports.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2,
    K_NOP    = 2'd3
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             clear_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (clear_i) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop_i)  head_q <= head_q + TAG_W'(1);
      if (push_i) tail_q <= tail_q + TAG_W'(1);
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
  p_ptr_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o || empty_o) |-> (head_q == tail_q));
  p_head_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clear_i) |=> head_o == TAG_W'($past(head_o) + TAG_W'(1)));
  p_clear_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (empty_o && head_o == '0 && tail_o == '0));
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int XLEN    = 32,
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2,
  localparam int TAG_W  = $clog2(DEPTH)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clear_i,
  input  logic                            alloc_i,
  input  logic [TAG_W-1:0]                alloc_tag_i,
  input  rob_kind_e                       alloc_kind_i,
  input  logic [REG_W-1:0]                alloc_dest_i,
  input  logic                            cdb_valid_i,
  input  logic [TAG_W-1:0]                cdb_tag_i,
  input  logic [XLEN-1:0]                 cdb_value_i,
  input  logic                            cdb_mis_i,
  input  logic                            retire_i,
  input  logic [TAG_W-1:0]                head_i,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]   rd_tag_i,
  output logic [NUM_SRC-1:0]              rd_done_o,
  output logic [NUM_SRC-1:0][XLEN-1:0]    rd_value_o,
  output logic                            head_valid_o,
  output logic                            head_done_o,
  output logic                            head_mis_o,
  output rob_kind_e                       head_kind_o,
  output logic [REG_W-1:0]                head_dest_o,
  output logic [XLEN-1:0]                 head_value_o
);
  logic [DEPTH-1:0] valid_q, done_q, mis_q;
  rob_kind_e        kind_q  [DEPTH];
  logic [REG_W-1:0] dest_q  [DEPTH];
  logic [XLEN-1:0]  value_q [DEPTH];

  logic cdb_hit;
  assign cdb_hit = cdb_valid_i && valid_q[cdb_tag_i] && !done_q[cdb_tag_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      done_q  <= '0;
      mis_q   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i]  <= K_NOP;
        dest_q[i]  <= '0;
        value_q[i] <= '0;
      end
    end else if (clear_i) begin
      valid_q <= '0;
      done_q  <= '0;
      mis_q   <= '0;
    end else begin
      if (alloc_i) begin
        valid_q[alloc_tag_i] <= 1'b1;
        done_q[alloc_tag_i]  <= 1'b0;
        mis_q[alloc_tag_i]   <= 1'b0;
        kind_q[alloc_tag_i]  <= alloc_kind_i;
        dest_q[alloc_tag_i]  <= alloc_dest_i;
        value_q[alloc_tag_i] <= '0;
      end
      if (cdb_hit) begin
        done_q[cdb_tag_i]  <= 1'b1;
        mis_q[cdb_tag_i]   <= cdb_mis_i;
        value_q[cdb_tag_i] <= cdb_value_i;
      end
      if (retire_i) valid_q[head_i] <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_rd
    assign rd_done_o[g]  = valid_q[rd_tag_i[g]] && done_q[rd_tag_i[g]];
    assign rd_value_o[g] = value_q[rd_tag_i[g]];
  end

  assign head_valid_o = valid_q[head_i];
  assign head_done_o  = done_q[head_i];
  assign head_mis_o   = mis_q[head_i];
  assign head_kind_o  = kind_q[head_i];
  assign head_dest_o  = dest_q[head_i];
  assign head_value_o = value_q[head_i];

  p_cdb_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cdb_hit && !clear_i) |=>
      (done_q[$past(cdb_tag_i)] && value_q[$past(cdb_tag_i)] == $past(cdb_value_i)));
  p_retire_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |-> (valid_q[head_i] && done_q[head_i]));
  p_alloc_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_q[alloc_tag_i]);
endmodule

// File: rtl/rob_status.sv
module rob_status #(
  parameter int NREG    = 32,
  parameter int TAG_W   = 3,
  parameter int NUM_SRC = 2,
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            flush_i,
  input  logic                            set_i,
  input  logic [REG_W-1:0]                set_idx_i,
  input  logic [TAG_W-1:0]                set_tag_i,
  input  logic                            clr_i,
  input  logic [REG_W-1:0]                clr_idx_i,
  input  logic [TAG_W-1:0]                clr_tag_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   rd_idx_i,
  output logic [NUM_SRC-1:0]              rd_busy_o,
  output logic [NUM_SRC-1:0][TAG_W-1:0]   rd_tag_o
);
  logic [NREG-1:0]  map_valid_q;
  logic [TAG_W-1:0] map_tag_q [NREG];
  logic             clr_match;

  assign clr_match = clr_i && map_valid_q[clr_idx_i] && (map_tag_q[clr_idx_i] == clr_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_valid_q <= '0;
      for (int i = 0; i < NREG; i++) map_tag_q[i] <= '0;
    end else if (flush_i) begin
      map_valid_q <= '0;
    end else begin
      if (clr_match) map_valid_q[clr_idx_i] <= 1'b0;
      // a same-cycle allocation to the same register wins over the clear
      if (set_i) begin
        map_valid_q[set_idx_i] <= 1'b1;
        map_tag_q[set_idx_i]   <= set_tag_i;
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_rd
    assign rd_busy_o[g] = map_valid_q[rd_idx_i[g]];
    assign rd_tag_o[g]  = map_tag_q[rd_idx_i[g]];
  end

  p_keep_younger_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !flush_i && map_valid_q[clr_idx_i] && map_tag_q[clr_idx_i] != clr_tag_i)
      |=> map_valid_q[$past(clr_idx_i)]);
  p_set_map_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !flush_i) |=>
      (map_valid_q[$past(set_idx_i)] && map_tag_q[$past(set_idx_i)] == $past(set_tag_i)));
  p_flush_map_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (map_valid_q == '0));
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int XLEN    = 32,
  parameter int NREG    = 32,
  parameter int NUM_SRC = 2,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           alloc_req_i,
  input  logic                           rs_free_i,
  input  logic [1:0]                     alloc_kind_i,
  input  logic [REG_W-1:0]               alloc_dest_i,
  output logic                           alloc_grant_o,
  output logic [TAG_W-1:0]               alloc_tag_o,
  output logic                           full_o,
  output logic                           empty_o,
  input  logic                           cdb_valid_i,
  input  logic [TAG_W-1:0]               cdb_tag_i,
  input  logic [XLEN-1:0]                cdb_value_i,
  input  logic                           cdb_mispredict_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]  src_reg_i,
  output logic [NUM_SRC-1:0]             src_busy_o,
  output logic [NUM_SRC-1:0]             src_ready_o,
  output logic [NUM_SRC-1:0][TAG_W-1:0]  src_tag_o,
  output logic [NUM_SRC-1:0][XLEN-1:0]   src_value_o,
  output logic                           commit_valid_o,
  output logic                           commit_reg_we_o,
  output logic                           commit_store_o,
  output logic [REG_W-1:0]               commit_idx_o,
  output logic [XLEN-1:0]                commit_value_o,
  output logic [TAG_W-1:0]               commit_tag_o,
  output logic                           flush_o
);
  logic [TAG_W-1:0] head, tail;
  logic             full, empty;
  logic             grant, retire, flush;
  rob_kind_e        kind_in;
  logic             head_valid, head_done, head_mis;
  rob_kind_e        head_kind;
  logic [REG_W-1:0] head_dest;
  logic [XLEN-1:0]  head_value;
  logic [NUM_SRC-1:0]            map_busy, slot_done;
  logic [NUM_SRC-1:0][TAG_W-1:0] map_tag;
  logic [NUM_SRC-1:0][XLEN-1:0]  slot_value;

  assign kind_in = rob_kind_e'(alloc_kind_i);
  assign flush   = head_valid && head_done && head_mis && (head_kind == K_BRANCH);
  assign retire  = head_valid && head_done && !flush;
  assign grant   = alloc_req_i && rs_free_i && !full && !flush;

  rob_ptrs #(.DEPTH(DEPTH)) i_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (grant),
    .pop_i   (retire),
    .clear_i (flush),
    .head_o  (head),
    .tail_o  (tail),
    .full_o  (full),
    .empty_o (empty)
  );

  rob_store #(
    .DEPTH(DEPTH), .XLEN(XLEN), .REG_W(REG_W), .NUM_SRC(NUM_SRC)
  ) i_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (flush),
    .alloc_i      (grant),
    .alloc_tag_i  (tail),
    .alloc_kind_i (kind_in),
    .alloc_dest_i (alloc_dest_i),
    .cdb_valid_i  (cdb_valid_i),
    .cdb_tag_i    (cdb_tag_i),
    .cdb_value_i  (cdb_value_i),
    .cdb_mis_i    (cdb_mispredict_i),
    .retire_i     (retire),
    .head_i       (head),
    .rd_tag_i     (map_tag),
    .rd_done_o    (slot_done),
    .rd_value_o   (slot_value),
    .head_valid_o (head_valid),
    .head_done_o  (head_done),
    .head_mis_o   (head_mis),
    .head_kind_o  (head_kind),
    .head_dest_o  (head_dest),
    .head_value_o (head_value)
  );

  rob_status #(.NREG(NREG), .TAG_W(TAG_W), .NUM_SRC(NUM_SRC)) i_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .set_i     (grant && (kind_in == K_REG)),
    .set_idx_i (alloc_dest_i),
    .set_tag_i (tail),
    .clr_i     (retire && (head_kind == K_REG)),
    .clr_idx_i (head_dest),
    .clr_tag_i (head),
    .rd_idx_i  (src_reg_i),
    .rd_busy_o (map_busy),
    .rd_tag_o  (map_tag)
  );

  assign alloc_grant_o   = grant;
  assign alloc_tag_o     = tail;
  assign full_o          = full;
  assign empty_o         = empty;
  assign src_busy_o      = map_busy;
  assign src_ready_o     = map_busy & slot_done;
  assign src_tag_o       = map_tag;
  assign src_value_o     = slot_value;
  assign commit_valid_o  = retire;
  assign commit_reg_we_o = retire && (head_kind == K_REG);
  assign commit_store_o  = retire && (head_kind == K_STORE);
  assign commit_idx_o    = head_dest;
  assign commit_value_o  = head_value;
  assign commit_tag_o    = head;
  assign flush_o         = flush;

  p_flush_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (!flush_o && !commit_valid_o && empty_o));
  p_grant_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_grant_o && !commit_valid_o) |=> !empty_o);
  p_kind_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({commit_reg_we_o, commit_store_o, flush_o}) <= 1);
  p_commit_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |-> !empty_o);
endmodule

// File: tb/test_spec_rob.sv
`timescale 1ns/1ps
module test_spec_rob;
  localparam int TAG_W = 3;
  localparam int REG_W = 5;
  localparam int XLEN  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                     alloc_req = 0, rs_free = 0;
  logic [1:0]               alloc_kind = 0;
  logic [REG_W-1:0]         alloc_dest = 0;
  logic                     alloc_grant;
  logic [TAG_W-1:0]         alloc_tag;
  logic                     full, empty;
  logic                     cdb_valid = 0, cdb_mis = 0;
  logic [TAG_W-1:0]         cdb_tag = 0;
  logic [XLEN-1:0]          cdb_value = 0;
  logic [1:0][REG_W-1:0]    src_reg = '0;
  logic [1:0]               src_busy, src_ready;
  logic [1:0][TAG_W-1:0]    src_tag;
  logic [1:0][XLEN-1:0]     src_value;
  logic                     c_valid, c_we, c_st, flush;
  logic [REG_W-1:0]         c_idx;
  logic [XLEN-1:0]          c_val;
  logic [TAG_W-1:0]         c_tag;

  spec_rob i_spec_rob (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_req_i(alloc_req), .rs_free_i(rs_free), .alloc_kind_i(alloc_kind),
    .alloc_dest_i(alloc_dest), .alloc_grant_o(alloc_grant), .alloc_tag_o(alloc_tag),
    .full_o(full), .empty_o(empty),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_value_i(cdb_value),
    .cdb_mispredict_i(cdb_mis),
    .src_reg_i(src_reg), .src_busy_o(src_busy), .src_ready_o(src_ready),
    .src_tag_o(src_tag), .src_value_o(src_value),
    .commit_valid_o(c_valid), .commit_reg_we_o(c_we), .commit_store_o(c_st),
    .commit_idx_o(c_idx), .commit_value_o(c_val), .commit_tag_o(c_tag),
    .flush_o(flush)
  );

  // program table: kind (0 reg, 1 store, 2 branch, 3 nop), destination, result
  localparam logic [1:0]       T_KIND [8] = '{2'd0, 2'd1, 2'd0, 2'd2, 2'd0, 2'd0, 2'd3, 2'd0};
  localparam logic [REG_W-1:0] T_DEST [8] = '{5'd3, 5'd4, 5'd5, 5'd0, 5'd6, 5'd7, 5'd0, 5'd3};
  localparam logic [XLEN-1:0]  T_VAL  [8] = '{32'h11, 32'h22, 32'h33, 32'h0,
                                              32'h55, 32'h66, 32'h0, 32'h88};
  localparam logic [TAG_W-1:0] T_ORDER [8] = '{3'd5, 3'd2, 3'd7, 3'd0, 3'd1, 3'd3, 3'd6, 3'd4};

  int checks = 0, errors = 0;
  bit finished = 0;

  // commit monitor
  int               log_n = 0, flush_n = 0;
  logic [TAG_W-1:0] log_tag [64];
  logic             log_we [64], log_st [64];
  logic [REG_W-1:0] log_idx [64];
  logic [XLEN-1:0]  log_val [64];
  always @(negedge clk) begin
    if (rst_n && c_valid && log_n < 64) begin
      log_tag[log_n] <= c_tag; log_we[log_n] <= c_we; log_st[log_n] <= c_st;
      log_idx[log_n] <= c_idx; log_val[log_n] <= c_val;
      log_n <= log_n + 1;
    end
    if (rst_n && flush) flush_n <= flush_n + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic alloc_op(input logic [1:0] k, input logic [REG_W-1:0] d,
                          output logic g, output logic [TAG_W-1:0] t);
    @(negedge clk);
    alloc_req = 1; rs_free = 1; alloc_kind = k; alloc_dest = d;
    #0.5; g = alloc_grant; t = alloc_tag;
    @(posedge clk); #0.5;
    alloc_req = 0;
  endtask

  task automatic bcast(input logic [TAG_W-1:0] t, input logic [XLEN-1:0] v, input logic m);
    @(negedge clk);
    cdb_valid = 1; cdb_tag = t; cdb_value = v; cdb_mis = m;
    @(posedge clk); #0.5;
    cdb_valid = 0; cdb_mis = 0;
  endtask

  task automatic query(input int p, input logic [REG_W-1:0] r, output logic b, output logic rd,
                       output logic [TAG_W-1:0] t, output logic [XLEN-1:0] v);
    @(negedge clk);
    src_reg[p] = r;
    #0.5; b = src_busy[p]; rd = src_ready[p]; t = src_tag[p]; v = src_value[p];
  endtask

  task automatic check_log(input int i, input logic [TAG_W-1:0] et, input logic [1:0] k,
                           input logic [REG_W-1:0] ed, input logic [XLEN-1:0] ev, input string req);
    bit ok;
    ok = (log_tag[i] == et) && (log_we[i] == (k == 2'd0)) && (log_st[i] == (k == 2'd1));
    if (k == 2'd0 || k == 2'd1) ok = ok && (log_idx[i] == ed) && (log_val[i] == ev);
    chk(ok, req, {29'd0, log_tag[i], log_we[i], log_st[i], log_val[i]},
                 {29'd0, et, (k == 2'd0), (k == 2'd1), ev});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 20000, 0);
    finish_run();
  end

  initial begin
    logic g, b, rd;
    logic [TAG_W-1:0] t;
    logic [XLEN-1:0] v;
    int base, fbase;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #0.5;
    // R1: reset state
    chk(empty && !full && !c_valid && !flush && alloc_tag == 0, "R1",
        {empty, full, c_valid, flush, alloc_tag}, {4'b1000, 3'd0});

    // R2: no free station -> no grant
    @(negedge clk); alloc_req = 1; rs_free = 0; #0.5;
    chk(!alloc_grant, "R2 station busy", alloc_grant, 0);
    @(posedge clk); #0.5; alloc_req = 0;

    // table walk: allocate
    base = log_n;
    for (int i = 0; i < 8; i++) begin
      alloc_op(T_KIND[i], T_DEST[i], g, t);
      chk(g && t == TAG_W'(i), "R2 tag order", {g, t}, {1'b1, 3'(i)});
    end
    #0.5;
    chk(full && !empty, "R3 full", {full, empty}, 2'b10);
    alloc_op(2'd0, 5'd9, g, t);
    chk(!g, "R3 refused when full", g, 0);
    query(0, 5'd3, b, rd, t, v);
    chk(b && !rd && t == 3'd7, "R5 youngest writer", {b, rd, t}, {2'b10, 3'd7});
    query(1, 5'd9, b, rd, t, v);
    chk(!b, "R3 refused alloc left no mapping", b, 0);

    // table walk: broadcast out of order
    for (int j = 0; j < 8; j++) begin
      bcast(T_ORDER[j], T_VAL[T_ORDER[j]], 1'b0);
      if (j == 1) begin
        @(negedge clk);
        chk(log_n == base, "R6 no commit before head done", log_n - base, 0);
        query(1, 5'd7, b, rd, t, v);
        chk(b && rd && t == 3'd5 && v == 32'h66, "R5 forward completed", {b, rd, t, v},
            {2'b11, 3'd5, 32'h66});
      end
    end
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(log_n - base == 8, "R6 commit count", log_n - base, 8);
    for (int i = 0; i < 8; i++) check_log(base + i, TAG_W'(i), T_KIND[i], T_DEST[i], T_VAL[i], "R6 R7 commit");
    chk(flush_n == 0, "R7 correct branch no flush", flush_n, 0);
    chk(empty && !full, "R3 empty after drain", {empty, full}, 2'b10);
    query(0, 5'd3, b, rd, t, v);
    chk(!b, "R8 cleared by last writer", b, 0);

    // R4: broadcast to a free slot is ignored
    bcast(3'd1, 32'hDEAD, 1'b0);
    alloc_op(2'd0, 5'd10, g, t);
    chk(g && t == 3'd0, "R2 tag after wrap", {g, t}, {1'b1, 3'd0});
    alloc_op(2'd0, 5'd11, g, t);
    query(1, 5'd11, b, rd, t, v);
    chk(b && !rd && t == 3'd1, "R4 stale broadcast ignored", {b, rd, t}, {2'b10, 3'd1});
    bcast(3'd1, 32'h77, 1'b0);
    query(1, 5'd11, b, rd, t, v);
    chk(b && rd && v == 32'h77, "R4 capture", {b, rd, v}, {2'b11, 32'h77});
    bcast(3'd0, 32'h66, 1'b0);
    repeat (3) @(posedge clk);

    // R8: older writer commits, younger mapping survives
    alloc_op(2'd0, 5'd9, g, t);
    alloc_op(2'd0, 5'd9, g, t);
    bcast(3'd2, 32'h90, 1'b0);
    repeat (3) @(posedge clk);
    query(0, 5'd9, b, rd, t, v);
    chk(b && !rd && t == 3'd3, "R8 younger kept", {b, rd, t}, {2'b10, 3'd3});
    bcast(3'd3, 32'h91, 1'b0);
    repeat (3) @(posedge clk);
    query(0, 5'd9, b, rd, t, v);
    chk(!b, "R8 cleared on match", b, 0);

    // R2/R6: wraparound, reverse completion
    base = log_n;
    for (int i = 0; i < 7; i++) begin
      alloc_op(2'd0, REG_W'(12 + i), g, t);
      chk(g && t == TAG_W'(4 + i), "R2 wrap tag", {g, t}, {1'b1, 3'(4 + i)});
    end
    for (int i = 6; i >= 0; i--) begin
      bcast(TAG_W'(4 + i), 32'h100 + i, 1'b0);
      if (i == 1) begin
        @(negedge clk);
        chk(log_n == base, "R6 wrap hold", log_n - base, 0);
      end
    end
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(log_n - base == 7, "R6 wrap count", log_n - base, 7);
    for (int i = 0; i < 7; i++) check_log(base + i, TAG_W'(4 + i), 2'd0, REG_W'(12 + i), 32'h100 + i, "R6 wrap order");

    // R9: mispredicted branch flushes younger work
    base = log_n; fbase = flush_n;
    alloc_op(2'd2, 5'd0, g, t);
    chk(g && t == 3'd3, "R2 branch tag", {g, t}, {1'b1, 3'd3});
    alloc_op(2'd0, 5'd20, g, t);
    alloc_op(2'd1, 5'd21, g, t);
    bcast(3'd4, 32'hAA, 1'b0);
    bcast(3'd5, 32'hBB, 1'b0);
    bcast(3'd3, 32'h0, 1'b1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(flush_n - fbase == 1, "R9 single flush pulse", flush_n - fbase, 1);
    chk(log_n == base, "R9 no younger commit", log_n - base, 0);
    chk(empty && !full, "R9 empty after flush", {empty, full}, 2'b10);
    query(0, 5'd20, b, rd, t, v);
    chk(!b, "R9 status cleared", b, 0);
    alloc_op(2'd3, 5'd0, g, t);
    chk(g && t == 3'd0, "R9 tags restart", {g, t}, {1'b1, 3'd0});

    finish_run();
  end
endmodule